// File: doc/BRIEF.md
# Byte-Framed SPI Slave Port with Idle Timeout

This block is the serial front end of a converter-style peripheral. It runs entirely in a fast system clock domain. The chip select, serial clock and serial data inputs are oversampled through synchronisers. Serial clock edges are found in that domain, so the system clock must run at least four times faster than SCLK. Incoming bits are taken on falling SCLK edges, and outgoing bits are launched on rising edges. Every transfer is framed in bytes.

At the first rising edge of each byte, the host-side logic chooses the byte's direction with `xmit_sel`. In a transmit byte the port sends `tx_byte` MSB first. In a receive byte it assembles eight DIN bits and presents them with a one-cycle strobe. The serial data output has its own enable, so the pad can be tri-stated while the port is deselected.

Byte alignment is restored in two ways. Raising chip select resets the port. Alternatively, when `timeout_en` is set, SCLK held low long enough also resets it. The timeout lets a three-wire bus, with chip select tied low, recover from stray clock edges.

Top module: `spi_byte_port`

## Requirements
- R1: DIN is sampled on each falling SCLK edge, MSB first. After the eighth falling edge of a receive byte, `rx_data` holds the byte and `rx_valid` is high for exactly one system clock cycle.
- R2: DOUT changes only after rising SCLK edges. In a transmit byte it carries `tx_byte`, MSB first. `tx_byte` is captured at the first rising edge of the byte.
- R3: The bit counter wraps after eight falling edges, so back-to-back bytes with no idle gap are each framed correctly.
- R4: While CS is high, the bit counter and shift registers are cleared, DIN and SCLK activity is ignored, and `dout_oe` is low. After CS falls, `dout_oe` is high and the next byte starts at bit 7.
- R5: With `timeout_en` = 1, SCLK low (and CS low) for TIMEOUT_CYCLES consecutive system clocks resets the port as a CS cycle would, which restores byte alignment.
- R6: With `timeout_en` = 0, an arbitrarily long SCLK-low idle does not reset the port. A partially received byte continues with the next bits.
- R7: Half duplex. A byte begun with `xmit_sel` = 1 produces no `rx_valid`. A byte begun with `xmit_sel` = 0 drives DOUT low for all its bits.
- R8: While `rst` is high, `rx_valid`, `dout` and `dout_oe` are all low.
- R9: The idle counter clears whenever SCLK is high. SCLK-low periods that are each shorter than TIMEOUT_CYCLES never trigger a reset, even if together they exceed it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n_pin | input | 1 | Chip select, active low, asynchronous |
| sclk_pin | input | 1 | Serial clock, asynchronous, idles low |
| din_pin | input | 1 | Serial data in, asynchronous |
| timeout_en | input | 1 | Enables the SCLK-low idle timeout |
| xmit_sel | input | 1 | 1 = next byte transmits, 0 = next byte receives |
| tx_byte | input | DATA_W | Byte to send, sampled at byte start |
| rx_data | output | DATA_W | Last received byte |
| rx_valid | output | 1 | One-cycle strobe for a completed receive byte |
| dout | output | 1 | Serial data out |
| dout_oe | output | 1 | Output enable for the DOUT pad |

## Verification
The main bytewise path is driven with a table of receive and transmit bytes sent back to back. The table uses alternating, all-ones, all-zeros and asymmetric patterns. These separate bit-order errors, stuck bits and direction mix-ups.

Realignment is tried three ways, each from a deliberately truncated byte:
- a CS cycle;
- an enabled timeout;
- a disabled timeout.

The expected result after the disabled timeout is a byte that straddles the idle period. Two sub-limit SCLK-low gaps separated by a single bit show that the counter restarts on every high SCLK phase rather than accumulating.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;
  typedef enum logic {
    DIR_RX = 1'b0,
    DIR_TX = 1'b1
  } byte_dir_e;

  localparam int SYNC_DEPTH_DEFAULT = 2;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_edge_detect.sv
module spi_edge_detect (
  input  logic clk,
  input  logic rst,
  input  logic level,
  output logic rise,
  output logic fall
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= level;
  end

  assign rise = level & ~prev_q;
  assign fall = ~level & prev_q;
endmodule

// File: rtl/spi_idle_timer.sv
module spi_idle_timer #(
  parameter int LIMIT = 65536
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic sclk_lvl,
  input  logic cs_lvl,
  output logic expire
);
  localparam int CNT_W = $clog2(LIMIT + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(LIMIT - 1);
  localparam logic [CNT_W-1:0] SAT_VAL  = CNT_W'(LIMIT);

  logic [CNT_W-1:0] cnt_q;
  logic             active;
  logic             expire_q;

  assign active = enable & ~sclk_lvl & ~cs_lvl;

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      cnt_q    <= '0;
      expire_q <= 1'b0;
    end else begin
      expire_q <= (cnt_q == LAST_IDX);
      if (cnt_q != SAT_VAL) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expire = expire_q;
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
  import spi_port_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              rise,
  input  logic              fall,
  input  logic              din,
  input  logic              xmit_sel,
  input  logic [DATA_W-1:0] tx_byte,
  output logic              dout,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid
);
  localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  logic [BIT_W-1:0]  bit_cnt;
  logic [DATA_W-1:0] tx_sh;
  logic [DATA_W-2:0] rx_sh;
  byte_dir_e         dir_q;
  logic              dout_q;
  logic [DATA_W-1:0] rx_data_q;
  logic              rx_valid_q;

  always_ff @(posedge clk) begin
    rx_valid_q <= 1'b0;
    if (clear) begin
      bit_cnt <= '0;
      tx_sh   <= '0;
      rx_sh   <= '0;
      dir_q   <= DIR_RX;
      dout_q  <= 1'b0;
    end else begin
      if (rise) begin
        if (bit_cnt == '0) begin
          dir_q <= xmit_sel ? DIR_TX : DIR_RX;
          if (xmit_sel) begin
            dout_q <= tx_byte[DATA_W-1];
            tx_sh  <= tx_byte << 1;
          end else begin
            dout_q <= 1'b0;
          end
        end else if (dir_q == DIR_TX) begin
          dout_q <= tx_sh[DATA_W-1];
          tx_sh  <= tx_sh << 1;
        end else begin
          dout_q <= 1'b0;
        end
      end
      if (fall) begin
        bit_cnt <= (bit_cnt == LAST_BIT) ? '0 : bit_cnt + 1'b1;
        if (dir_q == DIR_RX) begin
          rx_sh <= {rx_sh[DATA_W-3:0], din};
          if (bit_cnt == LAST_BIT) rx_valid_q <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data_q <= '0;
    end else if (!clear && fall && dir_q == DIR_RX && bit_cnt == LAST_BIT) begin
      rx_data_q <= {rx_sh, din};
    end
  end

  assign dout     = dout_q;
  assign rx_data  = rx_data_q;
  assign rx_valid = rx_valid_q;
endmodule

// File: rtl/spi_byte_port.sv
module spi_byte_port
  import spi_port_pkg::*;
#(
  parameter int DATA_W         = 8,
  parameter int SYNC_STAGES    = SYNC_DEPTH_DEFAULT,
  parameter int TIMEOUT_CYCLES = 65536
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n_pin,
  input  logic              sclk_pin,
  input  logic              din_pin,
  input  logic              timeout_en,
  input  logic              xmit_sel,
  input  logic [DATA_W-1:0] tx_byte,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              dout,
  output logic              dout_oe
);
  logic [2:0] pins_s;
  logic       cs_s, sclk_s, din_s;
  logic       sclk_rise, sclk_fall;
  logic       to_pulse;
  logic       port_clear;
  logic       oe_q;

  spi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({cs_n_pin, sclk_pin, din_pin}),
    .q   (pins_s)
  );

  assign cs_s   = pins_s[2];
  assign sclk_s = pins_s[1];
  assign din_s  = pins_s[0];

  spi_edge_detect u_edge (
    .clk   (clk),
    .rst   (rst),
    .level (sclk_s),
    .rise  (sclk_rise),
    .fall  (sclk_fall)
  );

  spi_idle_timer #(.LIMIT(TIMEOUT_CYCLES)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .enable   (timeout_en),
    .sclk_lvl (sclk_s),
    .cs_lvl   (cs_s),
    .expire   (to_pulse)
  );

  assign port_clear = rst | cs_s | to_pulse;

  spi_shift_engine #(.DATA_W(DATA_W)) u_engine (
    .clk      (clk),
    .rst      (rst),
    .clear    (port_clear),
    .rise     (sclk_rise),
    .fall     (sclk_fall),
    .din      (din_s),
    .xmit_sel (xmit_sel),
    .tx_byte  (tx_byte),
    .dout     (dout),
    .rx_data  (rx_data),
    .rx_valid (rx_valid)
  );

  always_ff @(posedge clk) begin
    if (rst) oe_q <= 1'b0;
    else     oe_q <= ~cs_s;
  end

  assign dout_oe = oe_q;
endmodule

// File: rtl/spi_byte_port_chk.sv
module spi_byte_port_chk (
  input logic clk,
  input logic rst,
  input logic cs_lvl,
  input logic sclk_lvl,
  input logic timeout_en,
  input logic rise,
  input logic port_clear,
  input logic expire,
  input logic dout,
  input logic dout_oe,
  input logic rx_valid
);
  assert_strobe_single_R1: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  assert_dout_on_rise_R2: assert property (@(posedge clk) disable iff (rst)
    !$stable(dout) |-> ($past(rise) || $past(port_clear)));

  assert_oe_off_deselected_R4: assert property (@(posedge clk) disable iff (rst)
    cs_lvl |=> !dout_oe);

  assert_timeout_needs_idle_R5: assert property (@(posedge clk) disable iff (rst)
    expire |-> $past(timeout_en && !sclk_lvl && !cs_lvl));

  assert_reset_quiet_R8: assert property (@(posedge clk)
    rst |=> (!rx_valid && !dout_oe && !dout));
endmodule

bind spi_byte_port spi_byte_port_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .cs_lvl     (cs_s),
  .sclk_lvl   (sclk_s),
  .timeout_en (timeout_en),
  .rise       (sclk_rise),
  .port_clear (port_clear),
  .expire     (to_pulse),
  .dout       (dout),
  .dout_oe    (dout_oe),
  .rx_valid   (rx_valid)
);

// File: tb/spi_byte_port_test.sv
`timescale 1ns/1ps
module spi_byte_port_test;
  localparam int TO   = 256;
  localparam int HALF = 6;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs_n = 1'b1, sclk = 1'b0, din = 1'b0;
  logic       to_en = 1'b0, xsel = 1'b0;
  logic [7:0] txb = 8'h00;
  logic [7:0] rx_data;
  logic       rx_valid, dout, dout_oe;

  int tests = 0, fails = 0;
  int rx_cnt = 0;
  logic [7:0] rx_last = 8'h00;

  always #2.5 clk = ~clk;

  spi_byte_port #(.DATA_W(8), .TIMEOUT_CYCLES(TO)) uut (
    .clk(clk), .rst(rst), .cs_n_pin(cs_n), .sclk_pin(sclk), .din_pin(din),
    .timeout_en(to_en), .xmit_sel(xsel), .tx_byte(txb),
    .rx_data(rx_data), .rx_valid(rx_valid), .dout(dout), .dout_oe(dout_oe)
  );

  always @(negedge clk) if (rx_valid) begin
    rx_cnt  <= rx_cnt + 1;
    rx_last <= rx_data;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic one_bit(input logic b, output logic o);
    @(negedge clk);
    sclk = 1'b1;
    din  = b;
    wait_clk(HALF);
    o = dout;
    sclk = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic send_byte(input logic [7:0] mosi, output logic [7:0] miso);
    for (int i = 7; i >= 0; i--) begin
      logic o;
      one_bit(mosi[i], o);
      miso[i] = o;
    end
  endtask

  task automatic send_bits(input int n, input logic b);
    for (int i = 0; i < n; i++) begin
      logic o;
      one_bit(b, o);
    end
  endtask

  // vector: [16] xmit_sel, [15:8] DIN byte, [7:0] tx_byte
  localparam logic [16:0] VEC [8] = '{
    {1'b0, 8'hA5, 8'h00},
    {1'b0, 8'hFF, 8'h00},
    {1'b1, 8'h00, 8'h5A},
    {1'b0, 8'h00, 8'hFF},
    {1'b1, 8'hFF, 8'hC3},
    {1'b1, 8'h12, 8'h01},
    {1'b0, 8'h81, 8'h00},
    {1'b1, 8'h00, 8'h80}
  };

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] miso;
    int base;

    // R8: reset state
    wait_clk(6);
    check(!rx_valid && !dout && !dout_oe, "R8 reset outputs",
          {rx_valid, dout, dout_oe}, 0);
    rst = 1'b0;
    wait_clk(6);
    check(!dout_oe, "R4 oe low while deselected", dout_oe, 0);
    cs_n = 1'b0;
    wait_clk(6);
    check(dout_oe, "R4 oe high after select", dout_oe, 1);

    // R1 R2 R3 R7: back-to-back table
    for (int v = 0; v < 8; v++) begin
      base = rx_cnt;
      xsel = VEC[v][16];
      txb  = VEC[v][7:0];
      send_byte(VEC[v][15:8], miso);
      wait_clk(4);
      if (VEC[v][16]) begin
        check(miso == VEC[v][7:0], "R2 transmit bits MSB first", miso, VEC[v][7:0]);
        check(rx_cnt == base, "R7 no strobe in transmit byte", rx_cnt - base, 0);
      end else begin
        check(rx_cnt == base + 1 && rx_last == VEC[v][15:8], "R1 R3 received byte",
              rx_last, VEC[v][15:8]);
        check(miso == 8'h00, "R7 dout low in receive byte", miso, 0);
      end
    end
    xsel = 1'b0;

    // R4: CS abort mid-byte, activity while deselected is ignored
    send_bits(3, 1'b1);
    cs_n = 1'b1;
    wait_clk(6);
    check(!dout_oe, "R4 oe low after CS raised", dout_oe, 0);
    base = rx_cnt;
    send_bits(8, 1'b1);
    wait_clk(4);
    check(rx_cnt == base, "R4 bits ignored while deselected", rx_cnt - base, 0);
    cs_n = 1'b0;
    wait_clk(6);
    send_byte(8'h3C, miso);
    wait_clk(4);
    check(rx_cnt == base + 1 && rx_last == 8'h3C, "R4 realigned after CS cycle",
          rx_last, 8'h3C);

    // R5: enabled timeout realigns
    to_en = 1'b1;
    send_bits(3, 1'b1);
    wait_clk(TO + 30);
    base = rx_cnt;
    send_byte(8'h96, miso);
    wait_clk(4);
    check(rx_cnt == base + 1 && rx_last == 8'h96, "R5 timeout realigns",
          rx_last, 8'h96);

    // R9: two sub-limit gaps do not accumulate
    base = rx_cnt;
    send_bits(3, 1'b0);
    wait_clk(TO / 2 + 20);
    send_bits(1, 1'b1);
    wait_clk(TO / 2 + 20);
    send_bits(4, 1'b1);
    wait_clk(4);
    check(rx_cnt == base + 1 && rx_last == 8'h1F, "R9 split idle keeps alignment",
          rx_last, 8'h1F);

    // R6: disabled timeout keeps the partial byte
    to_en = 1'b0;
    send_bits(3, 1'b1);
    wait_clk(TO + 30);
    base = rx_cnt;
    send_bits(5, 1'b0);
    wait_clk(4);
    check(rx_cnt == base + 1 && rx_last == 8'hE0, "R6 no reset without enable",
          rx_last, 8'hE0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule